// File: doc/BRIEF.md
# Frame-Rate-Control Gray-Scale Modulator

This block turns one display row of 2-bit pixel codes into one on/off drive decision per column. Four gray levels come from a three-frame cycle: the darkest level is never driven, the brightest always is, and the two middle levels are driven in one or two of every three frames. So that neighbouring pixels do not flicker together, the frame in which a pixel is driven is shifted by its position inside a 3-column by 3-line tile.

The timing generator around the block supplies the row's pixel codes together with a frame phase, a line phase and the column phase of the row's first pixel, each a count 0, 1 or 2. A row strobe loads the decisions into the output register. A polarity select reverses the code-to-level mapping, and a display-off input blanks every output.

Top module: `frcGrayMod`

## Requirements
- R1: While reset is low, and after it until the first load, every bit of `driveOn` is 0 (OFF).
- R2: `driveOn` changes only on a clock edge where `rowStrobe` or `displayOff` is high; on other edges it holds.
- R3: With `codeInvert` low, code 00 gives OFF and code 11 gives ON in every frame, column and line phase.
- R4: Pixel i sits at bits [2i+1:2i] of `pixCodes`, and its tile column is (`colPhase` + i) mod 3. Its slot is s = (`framePhase` + tile column + `linePhase`) mod 3.
- R5: The level-1 code (01 with `codeInvert` low) drives ON only when s is 0.
- R6: The level-2 code (10 with `codeInvert` low) drives ON when s is 0 or 1 and OFF when s is 2.
- R7: With `codeInvert` high, the level is the bitwise complement of the code: 11 is level 0 (OFF), 10 is level 1, 01 is level 2, 00 is level 3 (ON).
- R8: Over the three frame phases, with line and column fixed, a level-1 pixel is ON in exactly one frame and a level-2 pixel in exactly two.
- R9: On an edge with `displayOff` high, every output becomes OFF whatever the pixel codes and `rowStrobe`, and the outputs stay OFF until a later load.
- R10: On an edge where `rowStrobe` is high and `displayOff` is low, `driveOn` takes the new decisions, visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rowStrobe | input | 1 | Load the row's decisions on this edge |
| pixCodes | input | 2*NUM_COLS | Pixel codes, pixel i at bits [2i+1:2i] |
| framePhase | input | 2 | Frame count mod 3 (0..2) |
| linePhase | input | 2 | Line count mod 3 (0..2) |
| colPhase | input | 2 | Tile column of pixel 0 (0..2) |
| codeInvert | input | 1 | Reverse the code-to-level mapping |
| displayOff | input | 1 | Force all outputs OFF |
| driveOn | output | NUM_COLS | Registered per-column drive decision, 1 = ON |

## Verification
The hardest case to reach from the ports is the spread of a middle level across the whole tile. Each of the nine column and line offsets must be seen in all three frames, and only then does a wrong offset or a wrong slot comparison show. The bench fills a row with one mid-level code, so that adjacent pixels fall on successive tile columns. It then sweeps every frame, line and starting column phase, and also counts the ON frames per pixel over a full cycle.

// File: rtl/frcPkg.sv
package frcPkg;
  typedef struct packed {
    logic load;
    logic blank;
  } frcStrobes_t;

  localparam int PHASE_W = 2;
endpackage

// File: rtl/frcCtrl.sv
module frcCtrl
  import frcPkg::*;
(
  input  logic               rowStrobe,
  input  logic               displayOff,
  input  logic [PHASE_W-1:0] framePhase,
  input  logic [PHASE_W-1:0] linePhase,
  output frcStrobes_t        strobes,
  output logic [PHASE_W-1:0] basePhase
);
  logic [PHASE_W+1:0] rawSum;

  always_comb begin
    strobes.blank = displayOff;
    strobes.load  = rowStrobe & ~displayOff;
    rawSum    = (PHASE_W+2)'(framePhase) + (PHASE_W+2)'(linePhase);
    basePhase = PHASE_W'(rawSum % (PHASE_W+2)'(3));
  end
endmodule

// File: rtl/frcDatapath.sv
module frcDatapath
  import frcPkg::*;
#(
  parameter int NUM_COLS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  frcStrobes_t           strobes,
  input  logic [PHASE_W-1:0]    basePhase,
  input  logic [PHASE_W-1:0]    colPhase,
  input  logic                  codeInvert,
  input  logic [2*NUM_COLS-1:0] pixCodes,
  output logic [NUM_COLS-1:0]   driveOn
);
  localparam int SUM_W = PHASE_W + 2;

  logic [NUM_COLS-1:0] nextOn;

  for (genvar i = 0; i < NUM_COLS; i++) begin : g_col
    localparam logic [PHASE_W-1:0] COL_OFS = PHASE_W'(i % 3);
    logic [1:0]         level;
    logic [SUM_W-1:0]   rawSum;
    logic [PHASE_W-1:0] slot;

    always_comb begin
      level  = pixCodes[2*i +: 2] ^ {2{codeInvert}};
      rawSum = SUM_W'(basePhase) + SUM_W'(colPhase) + SUM_W'(COL_OFS);
      slot   = PHASE_W'(rawSum % SUM_W'(3));
      unique case (level)
        2'd0:    nextOn[i] = 1'b0;
        2'd1:    nextOn[i] = (slot == 2'd0);
        2'd2:    nextOn[i] = (slot != 2'd2);
        default: nextOn[i] = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              driveOn <= '0;
    else if (strobes.blank) driveOn <= '0;
    else if (strobes.load)  driveOn <= nextOn;
  end
endmodule

// File: rtl/frcGrayMod.sv
module frcGrayMod
  import frcPkg::*;
#(
  parameter int NUM_COLS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rowStrobe,
  input  logic [2*NUM_COLS-1:0] pixCodes,
  input  logic [1:0]            framePhase,
  input  logic [1:0]            linePhase,
  input  logic [1:0]            colPhase,
  input  logic                  codeInvert,
  input  logic                  displayOff,
  output logic [NUM_COLS-1:0]   driveOn
);
  frcStrobes_t        strobes;
  logic [PHASE_W-1:0] basePhase;

  frcCtrl ctrl_i (
    .rowStrobe (rowStrobe),
    .displayOff(displayOff),
    .framePhase(framePhase),
    .linePhase (linePhase),
    .strobes   (strobes),
    .basePhase (basePhase)
  );

  frcDatapath #(.NUM_COLS(NUM_COLS)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .basePhase (basePhase),
    .colPhase  (colPhase),
    .codeInvert(codeInvert),
    .pixCodes  (pixCodes),
    .driveOn   (driveOn)
  );
endmodule

// File: rtl/frcGrayModChecker.sv
module frcGrayModChecker #(
  parameter int NUM_COLS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  rowStrobe,
  input logic [2*NUM_COLS-1:0] pixCodes,
  input logic                  codeInvert,
  input logic                  displayOff,
  input logic [NUM_COLS-1:0]   driveOn
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!rowStrobe && !displayOff) |=> $stable(driveOn));

  assert_blank_R9: assert property (@(posedge clk) disable iff (!rstN)
    displayOff |=> (driveOn == '0));

  assert_code0_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rowStrobe && !codeInvert && pixCodes == '0) |=> (driveOn == '0));

  assert_code3_on_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rowStrobe && !displayOff && !codeInvert && pixCodes == '1) |=> (driveOn == '1));

  assert_invert_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rowStrobe && codeInvert && pixCodes == '1) |=> (driveOn == '0));
endmodule

bind frcGrayMod frcGrayModChecker #(.NUM_COLS(NUM_COLS)) checker_i (
  .clk       (clk),
  .rstN      (rstN),
  .rowStrobe (rowStrobe),
  .pixCodes  (pixCodes),
  .codeInvert(codeInvert),
  .displayOff(displayOff),
  .driveOn   (driveOn)
);

// File: tb/frcGrayMod_tb.sv
module frcGrayMod_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rowStrobe = 1'b0;
  logic [2*NC-1:0] pixCodes = '0;
  logic [1:0]    framePhase = '0, linePhase = '0, colPhase = '0;
  logic          codeInvert = 1'b0, displayOff = 1'b0;
  logic [NC-1:0] driveOn;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frcGrayMod #(.NUM_COLS(NC)) dut_i (
    .clk(clk), .rstN(rstN), .rowStrobe(rowStrobe), .pixCodes(pixCodes),
    .framePhase(framePhase), .linePhase(linePhase), .colPhase(colPhase),
    .codeInvert(codeInvert), .displayOff(displayOff), .driveOn(driveOn)
  );

  function automatic logic [NC-1:0] model(input logic [2*NC-1:0] codes, input logic inv,
                                          input int f, input int l, input int c);
    logic [NC-1:0] r;
    for (int i = 0; i < NC; i++) begin
      int lvl = int'(codes[2*i +: 2]);
      int s = (f + l + c + i) % 3;
      if (inv) lvl = 3 - lvl;
      r[i] = (lvl == 3) || (lvl == 1 && s == 0) || (lvl == 2 && s != 2);
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [NC-1:0] exp);
    checks++;
    if (driveOn !== exp) begin
      errors++;
      $display("FAIL %s: driveOn=%b expected=%b", req, driveOn, exp);
    end
  endtask

  task automatic loadRow(input logic [2*NC-1:0] codes, input int f, input int l,
                         input int c, input logic inv);
    @(negedge clk);
    pixCodes = codes; framePhase = 2'(f); linePhase = 2'(l); colPhase = 2'(c);
    codeInvert = inv; rowStrobe = 1'b1;
    @(negedge clk);
    rowStrobe = 1'b0;
  endtask

  task automatic testReset;
    check("R1", '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", '0);
  endtask

  task automatic testExtremes;
    for (int f = 0; f < 3; f++) begin
      loadRow('0, f, f, 2 - f, 1'b0);
      check("R3", '0);
      loadRow('1, f, 2 - f, f, 1'b0);
      check("R3", '1);
    end
  endtask

  task automatic testSweep;
    for (int lv = 1; lv <= 2; lv++)
      for (int f = 0; f < 3; f++)
        for (int l = 0; l < 3; l++)
          for (int c = 0; c < 3; c++) begin
            logic [2*NC-1:0] row = {NC{2'(lv)}};
            loadRow(row, f, l, c, 1'b0);
            check(lv == 1 ? "R5 R4" : "R6 R4", model(row, 1'b0, f, l, c));
          end
    loadRow(16'h1B6C, 1, 2, 0, 1'b0);
    check("R4 mixed", model(16'h1B6C, 1'b0, 1, 2, 0));
  endtask

  task automatic testInvert;
    loadRow('1, 0, 0, 0, 1'b1);
    check("R7 code11", '0);
    loadRow('0, 1, 1, 1, 1'b1);
    check("R7 code00", '1);
    for (int f = 0; f < 3; f++) begin
      loadRow(16'hE41B, f, 1, 2, 1'b1);
      check("R7 mixed", model(16'hE41B, 1'b1, f, 1, 2));
    end
  endtask

  task automatic testThreeFrames;
    for (int lv = 1; lv <= 2; lv++) begin
      int cnt [NC];
      for (int i = 0; i < NC; i++) cnt[i] = 0;
      for (int f = 0; f < 3; f++) begin
        loadRow({NC{2'(lv)}}, f, 2, 1, 1'b0);
        for (int i = 0; i < NC; i++) cnt[i] += int'(driveOn[i]);
      end
      for (int i = 0; i < NC; i++) begin
        checks++;
        if (cnt[i] != lv) begin
          errors++;
          $display("FAIL R8: pixel %0d on %0d frames expected=%0d", i, cnt[i], lv);
        end
      end
    end
  endtask

  task automatic testHoldAndBlank;
    logic [NC-1:0] held;
    loadRow(16'h9C63, 2, 0, 1, 1'b0);
    held = model(16'h9C63, 1'b0, 2, 0, 1);
    check("R10", held);
    @(negedge clk);
    pixCodes = '1; framePhase = 2'd0;
    @(negedge clk);
    check("R2 hold", held);
    displayOff = 1'b1; rowStrobe = 1'b1; pixCodes = '1;
    @(negedge clk);
    check("R9 blank with strobe", '0);
    rowStrobe = 1'b0;
    @(negedge clk);
    displayOff = 1'b0;
    @(negedge clk);
    check("R9 stays off", '0);
    loadRow('1, 0, 0, 0, 1'b0);
    check("R10 reload", '1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testExtremes();
    testSweep();
    testInvert();
    testThreeFrames();
    testHoldAndBlank();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule